// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a single-port synchronous static memory whose command, address, byte enables and write data are all captured on the rising clock edge. Each cycle carries one of three things: a fresh command with its own address, a continuation of the running burst, or a deselect. Read data comes out of an output register two enabled cycles after its command. Write data is sampled two enabled cycles after its command. Because reads and writes line up on the same data-bus slot, any mix of reads and writes can be issued back to back with no idle cycles when the direction changes.

A 2-bit burst counter walks the low address bits from the last loaded address. A mode input picks linear order (base plus count, modulo 4) or interleaved order (base XOR count). Every word is made of 9-bit byte lanes, each holding 8 data bits and 1 parity bit. Each lane has its own active-low write enable. A read that lands on a word whose write is still in flight receives the newer lane data. An active-low clock-enable freezes the whole block. A sleep input blocks new work but keeps the stored contents.

Top module: `nowait_sram`

## Requirements
- R1: The synchronous reset `rst` clears `rvalid` to 0 and leaves no burst active. A continuation issued straight after reset performs no access.
- R2: A read command sampled at enabled edge k drives `rdata` and raises `rvalid` after enabled edge k+2. Read and write commands may alternate every cycle with no idle cycles. A write in the final pipeline stage never raises `rvalid`.
- R3: A write command sampled at enabled edge k stores the `wdata` sampled at enabled edge k+2. Lane i is bits [9i+8:9i], with its parity bit at 9i+8, and lane i is written only when `bw_n[i]` is 0. Other lanes keep their contents.
- R4: With `adv`=1 and `burst_ilv`=0 latched at the burst's start, the n-th continuation accesses the base address with its low two bits replaced by (base[1:0] + n) mod 4.
- R5: With `burst_ilv`=1 latched at the burst's start, the n-th continuation accesses low bits base[1:0] XOR n. The upper address bits are unchanged.
- R6: A continuation repeats the read or write type of the command that started the burst. A continuation that follows a deselect is also a deselect.
- R7: A new command (`adv`=0) is a read or write only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. Otherwise it is a deselect: nothing is written and `rvalid` stays 0.
- R8: While `clk_en_n`=1, every input is ignored and all state holds, including memory contents, `rdata` and `rvalid`.
- R9: A read issued the cycle after a write to the same address returns the write's data on the lanes it enabled, and the older contents on the other lanes.
- R10: `rvalid` is 0 after any enabled edge where `oe`=0 or `sleep`=1. While `sleep`=1, new commands and continuations are deselects, and stored contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes all state |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| adv | input | 1 | 0 loads a new command, 1 continues the burst |
| we_n | input | 1 | 0 selects write, 1 selects read (new commands only) |
| bw_n | input | LANES | Active-low per-lane write enables |
| addr | input | ADDR_W | Word address for new commands |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe | input | 1 | Output enable, active high |
| sleep | input | 1 | Blocks new work while high |
| wdata | input | LANES*LANE_W | Write data, sampled two enabled cycles after its command |
| rdata | output | LANES*LANE_W | Registered read data |
| rvalid | output | 1 | High when `rdata` carries a fresh read result |

## Verification
The bench issues reads right after writes to the same word with partial lane enables. A design without bypass would return the stale lanes there, and one with a wrong merge would mix the wrong lanes. It runs four-beat bursts from unaligned bases in both orders. A counter that adds where it should XOR, or that carries into the upper address bits, reads the wrong words. It also freezes the clock enable while junk write commands sit on the inputs, and issues continuations after deselects, reset and sleep. A design that leaks through the freeze, or revives a dead burst, either corrupts memory or raises `rvalid` when no read was issued.

// File: rtl/nowait_sram_pkg.sv
package nowait_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/nowait_sram_burst.sv
// Command decode and 2-bit burst sequencer; produces the first pipeline stage.
module nowait_sram_burst
  import nowait_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  input  logic              adv,
  input  logic              we_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              burst_ilv,
  input  logic              sleep,
  output op_e               op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LANES-1:0]  be_q
);
  localparam int CNT_W = 2;

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ilv_q;
  op_e               kind_q;

  logic              chip_on;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [CNT_W-1:0]  low_bits;
  op_e               op_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    chip_on = !cs1_n && cs2 && !cs3_n && !sleep;
    cnt_nxt = cnt_q + 1'b1;
    low_bits = ilv_q ? (base_q[CNT_W-1:0] ^ cnt_nxt)
                     : (base_q[CNT_W-1:0] + cnt_nxt);
    if (!adv) begin
      op_d   = chip_on ? (we_n ? OP_RD : OP_WR) : OP_IDLE;
      addr_d = addr;
    end else begin
      op_d   = sleep ? OP_IDLE : kind_q;
      addr_d = {base_q[ADDR_W-1:CNT_W], low_bits};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
      ilv_q  <= 1'b0;
      kind_q <= OP_IDLE;
      op_q   <= OP_IDLE;
      addr_q <= '0;
      be_q   <= '0;
    end else if (en) begin
      if (!adv) begin
        base_q <= addr;
        cnt_q  <= '0;
        ilv_q  <= burst_ilv;
      end else begin
        cnt_q  <= cnt_nxt;
      end
      kind_q <= op_d;
      op_q   <= op_d;
      addr_q <= addr_d;
      be_q   <= ~bw_n;
    end
  end
endmodule

// File: rtl/nowait_sram_store.sv
// Storage array: byte-lane write, registered synchronous read (read-first).
module nowait_sram_store #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic                    wr,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES-1:0]        wbe,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rword
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = LANES * LANE_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      for (int i = 0; i < LANES; i++) begin
        if (wr && wbe[i]) mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
      end
      rword <= mem[raddr];
    end
  end
endmodule

// File: rtl/nowait_sram_out.sv
// Bypass from the in-flight write and the registered data output.
module nowait_sram_out
  import nowait_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  op_e                     op1,
  input  logic [ADDR_W-1:0]       a1,
  input  op_e                     op2,
  input  logic [ADDR_W-1:0]       a2,
  input  logic [LANES-1:0]        be2,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES*LANE_W-1:0] rword,
  input  logic                    oe,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);
  localparam int WORD_W = LANES * LANE_W;

  logic              hit_q;
  logic [WORD_W-1:0] fdata_q;
  logic [LANES-1:0]  fbe_q;
  logic [WORD_W-1:0] merged;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign merged[i*LANE_W +: LANE_W] = (hit_q && fbe_q[i]) ? fdata_q[i*LANE_W +: LANE_W]
                                                            : rword[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q   <= 1'b0;
      fdata_q <= '0;
      fbe_q   <= '0;
      rdata   <= '0;
      rvalid  <= 1'b0;
    end else if (en) begin
      hit_q   <= (op1 == OP_RD) && (op2 == OP_WR) && (a1 == a2);
      fdata_q <= wdata;
      fbe_q   <= be2;
      rvalid  <= (op2 == OP_RD) && oe && !sleep;
      if (op2 == OP_RD) rdata <= merged;
    end
  end
endmodule

// File: rtl/nowait_sram.sv
module nowait_sram
  import nowait_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clk_en_n,
  input  logic                    cs1_n,
  input  logic                    cs2,
  input  logic                    cs3_n,
  input  logic                    adv,
  input  logic                    we_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    burst_ilv,
  input  logic                    oe,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);
  localparam int WORD_W = LANES * LANE_W;

  logic              en;
  op_e               op1;
  logic [ADDR_W-1:0] a1;
  logic [LANES-1:0]  be1;
  op_e               op2;
  logic [ADDR_W-1:0] a2;
  logic [LANES-1:0]  be2;
  logic [WORD_W-1:0] rword;

  assign en = !clk_en_n;

  nowait_sram_burst #(.ADDR_W(ADDR_W), .LANES(LANES)) u_burst (
    .clk(clk), .rst(rst), .en(en),
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .adv(adv), .we_n(we_n), .bw_n(bw_n), .addr(addr),
    .burst_ilv(burst_ilv), .sleep(sleep),
    .op_q(op1), .addr_q(a1), .be_q(be1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op2 <= OP_IDLE;
      a2  <= '0;
      be2 <= '0;
    end else if (en) begin
      op2 <= op1;
      a2  <= a1;
      be2 <= be1;
    end
  end

  nowait_sram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk(clk), .en(en), .wr(op2 == OP_WR),
    .waddr(a2), .wbe(be2), .wdata(wdata),
    .raddr(a1), .rword(rword)
  );

  nowait_sram_out #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_out (
    .clk(clk), .rst(rst), .en(en),
    .op1(op1), .a1(a1), .op2(op2), .a2(a2), .be2(be2),
    .wdata(wdata), .rword(rword), .oe(oe), .sleep(sleep),
    .rdata(rdata), .rvalid(rvalid)
  );
endmodule

// File: rtl/nowait_sram_chk.sv
module nowait_sram_chk #(
  parameter int WORD_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_en_n,
  input logic              cs1_n,
  input logic              cs2,
  input logic              cs3_n,
  input logic              adv,
  input logic              oe,
  input logic              sleep,
  input logic [1:0]        op1,
  input logic [1:0]        op2,
  input logic [WORD_W-1:0] rdata,
  input logic              rvalid
);
  localparam logic [1:0] IDLE = 2'd0;
  localparam logic [1:0] WR   = 2'd2;

  assert_reset_R1: assert property (@(posedge clk) rst |=> !rvalid);

  assert_write_no_valid_R2: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && op2 == WR) |=> !rvalid);

  assert_dead_burst_R6: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && adv && op1 == IDLE) |=> (op1 == IDLE));

  assert_deselect_R7: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !adv && (cs1_n || !cs2 || cs3_n)) |=> (op1 == IDLE));

  assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    clk_en_n |=> ($stable(rvalid) && $stable(rdata) && $stable(op1)));

  assert_oe_off_R10: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !oe) |=> !rvalid);

  assert_sleep_R10: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && sleep) |=> !rvalid);
endmodule

bind nowait_sram nowait_sram_chk #(.WORD_W(LANES*LANE_W)) u_chk (
  .clk(clk), .rst(rst), .clk_en_n(clk_en_n),
  .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .adv(adv),
  .oe(oe), .sleep(sleep), .op1(op1), .op2(op2),
  .rdata(rdata), .rvalid(rvalid)
);

// File: tb/tb_nowait_sram.sv
module tb_nowait_sram;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clk_en_n = 1'b0;
  logic          cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1;
  logic          adv = 1'b0, we_n = 1'b1;
  logic [NL-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic          burst_ilv = 1'b0, oe = 1'b1, sleep = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rvalid;

  nowait_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n),
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .adv(adv), .we_n(we_n), .bw_n(bw_n), .addr(addr),
    .burst_ilv(burst_ilv), .oe(oe), .sleep(sleep),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  always #5 clk = ~clk;

  int    errors = 0;
  int    checks = 0;
  string phase  = "R1";
  logic [2:0] cs_off = 3'b000;
  int    wcnt = 0;

  // reference model state
  logic [DW-1:0] rmem [1<<AW];
  int            p1op = 0, p2op = 0, kind = 0;
  logic [AW-1:0] p1a = '0, p2a = '0, base = '0;
  logic [NL-1:0] p1be = '0, p2be = '0;
  logic [1:0]    bc = '0;
  logic          bilv = 1'b0;
  logic          exp_v = 1'b0, fz = 1'b0;
  logic [DW-1:0] q_d [$];
  string         q_t [$];
  logic          pv = 1'b0;
  logic [DW-1:0] pd = '0;

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // model: expected items pushed at each enabled edge
  always @(posedge clk) begin
    int nop;
    logic [AW-1:0] na;
    logic [1:0] lo;
    if (rst) begin
      p1op = 0; p2op = 0; kind = 0; bc = '0; exp_v = 1'b0; fz = 1'b0;
    end else if (clk_en_n) begin
      fz = 1'b1;
    end else begin
      fz = 1'b0;
      if (p2op == 2)
        for (int i = 0; i < NL; i++)
          if (p2be[i]) rmem[p2a][i*LW +: LW] = wdata[i*LW +: LW];
      exp_v = (p2op == 1) && oe && !sleep;
      if (exp_v) begin
        q_d.push_back(rmem[p2a]);
        q_t.push_back(phase);
      end
      if (!adv) begin
        nop  = (!cs1_n && cs2 && !cs3_n && !sleep) ? (we_n ? 1 : 2) : 0;
        base = addr; bc = 2'd0; bilv = burst_ilv; na = addr;
      end else begin
        bc  = bc + 2'd1;
        nop = sleep ? 0 : kind;
        lo  = bilv ? (base[1:0] ^ bc) : (base[1:0] + bc);
        na  = {base[AW-1:2], lo};
      end
      kind = nop;
      p2op = p1op; p2a = p1a; p2be = p1be;
      p1op = nop;  p1a = na;  p1be = ~bw_n;
    end
  end

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    logic [DW-1:0] e;
    if (fz) begin
      check(rvalid == pv && rdata == pd, "R8 frozen output", {rdata[DW-2:0], rvalid}, {pd[DW-2:0], pv});
    end else begin
      check(rvalid == exp_v, {phase, " rvalid"}, DW'(rvalid), DW'(exp_v));
      if (exp_v && q_d.size() > 0) begin
        e = q_d.pop_front();
        check(rdata == e, {q_t.pop_front(), " rdata"}, rdata, e);
      end
    end
    pv = rvalid; pd = rdata;
  end

  task automatic drive(input logic a_v, input logic w_n, input int a, input logic [NL-1:0] b_n);
    @(negedge clk);
    clk_en_n = 1'b0;
    cs1_n = cs_off[0]; cs2 = !cs_off[1]; cs3_n = cs_off[2];
    adv = a_v; we_n = w_n; addr = AW'(a); bw_n = b_n;
    wcnt++;
    wdata = {4'(wcnt), 32'(wcnt) * 32'h9E3779B1};
  endtask

  task automatic wr(input int a, input logic [NL-1:0] b_n); drive(1'b0, 1'b0, a, b_n); endtask
  task automatic rd(input int a); drive(1'b0, 1'b1, a, '1); endtask
  task automatic cont(); drive(1'b1, 1'b1, 0, '1); endtask
  task automatic idle();
    cs_off = 3'b001; drive(1'b0, 1'b1, 0, '1); cs_off = 3'b000;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rvalid == 1'b0, "R1 reset rvalid", DW'(rvalid), '0);
    @(negedge clk); rst = 1'b0;
    phase = "R1"; cont(); cont(); idle(); idle();

    phase = "R3"; for (int a = 0; a < 20; a++) wr(a, '0);
    idle(); idle();
    phase = "R2"; for (int a = 0; a < 8; a++) rd(a);
    wr(30, '0); rd(2); wr(31, '0); rd(30); rd(31); wr(2, '0); rd(2);
    idle(); idle();

    phase = "R3"; wr(3, 4'b1010); idle(); idle(); rd(3); wr(12, 4'b0111); idle(); rd(12); idle(); idle();

    phase = "R9"; wr(5, 4'b0101); rd(5); wr(6, 4'b1100); rd(6); rd(5); idle(); idle();
    wr(7, 4'b0000); idle(); rd(7); idle(); idle();

    phase = "R4"; burst_ilv = 1'b0; rd(6); cont(); cont(); cont(); idle(); idle();
    phase = "R5"; burst_ilv = 1'b1; rd(9); cont(); cont(); cont();
    rd(14); burst_ilv = 1'b0; cont(); cont(); cont(); idle(); idle();

    phase = "R6"; burst_ilv = 1'b0; wr(17, '0); cont(); cont(); cont();
    rd(16); cont(); cont(); cont(); idle(); cont(); cont(); idle(); idle();

    phase = "R7";
    cs_off = 3'b001; wr(0, '0); rd(0); cs_off = 3'b010; wr(0, '0); rd(0);
    cs_off = 3'b100; wr(0, '0); rd(0); cs_off = 3'b000; idle(); idle(); rd(0); idle(); idle();

    phase = "R8"; rd(4);
    @(negedge clk); clk_en_n = 1'b1; adv = 1'b0; we_n = 1'b0; addr = AW'(4); bw_n = '0; wdata = '1;
    repeat (3) @(negedge clk);
    rd(4); wr(8, '0); idle(); rd(8); idle(); idle();

    phase = "R10"; oe = 1'b0; rd(1); rd(2); idle(); idle(); oe = 1'b1; rd(1); idle(); idle();
    sleep = 1'b1; wr(10, '0); rd(10); cont(); idle(); idle();
    sleep = 1'b0; rd(10); cont(); idle(); idle();

    phase = "R2"; repeat (3) idle();
    check(q_d.size() == 0, "R2 queue drained", DW'(q_d.size()), '0);
    summary();
  end
endmodule